// File: doc/BRIEF.md
# Integer Operate Unit

This block is the integer execution stage of a 64-bit load/store processor core. Each clock it can accept one operation: an opcode, two register operands, an optional 8-bit literal that takes the place of the second operand, and the current value of the destination register. It produces, one clock later, the result word, a write-enable for the register file and an overflow-trap flag. It covers quadword and longword add and subtract (plain, overflow-checked and scaled), compares that write 0 or 1, the six two-input bitwise functions, conditional moves that test the first operand against zero, and logical and arithmetic shifts.

No condition codes exist: compares produce a boolean word and conditional moves carry their own test. Longword results are always returned sign-extended to the full width. A conditional move whose test fails drops its write-enable and returns the old destination value, so a register file may either honour the enable or write back unconditionally. Multiply, divide, floating point, register storage and the delivery of the trap are left to neighbouring blocks.

Top module: `iou_int_exec`

## Requirements
- R1: While reset is active, and until the internal reset release has been clocked through, out_valid, out_wr_en and out_trap are 0 regardless of in_valid.
- R2: out_valid, out_wr_en and out_trap reflect an input accepted with in_valid=1 exactly one clock later; a cycle with in_valid=0 produces out_valid=0, out_wr_en=0 and out_trap=0 one clock later.
- R3: With use_lit=1 the second operand is the 8-bit lit zero-extended to the full width, and opnd_b is ignored.
- R4: Quadword add (op 0) and subtract (op 1) return the sum or difference modulo 2^XLEN with out_wr_en=1 and out_trap=0, even on signed overflow.
- R5: Longword add (op 2), subtract (op 3) and the longword variants of R6 and R7 use only the low HALF bits of each operand and return the HALF-bit result sign-extended to XLEN bits.
- R6: Scaled forms (op 8 to 15; bit 0 selects shift by 3 over shift by 2, bit 1 selects subtract, bit 2 selects longword) shift the second operand left before adding or subtracting and never set out_trap.
- R7: Checked forms (op 4 quad add, 5 quad sub, 6 long add, 7 long sub) return the wrapped result with out_wr_en=1 and set out_trap exactly when the signed result does not fit in the operation width.
- R8: Compares write 1 when the condition holds and 0 otherwise: op 16 equal, 17 signed less-than, 18 signed less-or-equal, 19 unsigned less-than, 20 unsigned less-or-equal.
- R9: Bitwise ops: 24 AND, 25 OR, 26 XOR, 27 NAND, 28 NOR, 29 XNOR of the two operands.
- R10: Conditional moves test opnd_a as a signed value against zero (op 32 eq, 33 ne, 34 lt, 35 le, 36 ge, 37 gt) and, when true, return the second operand with out_wr_en=1.
- R11: When a conditional move's test is false, out_wr_en=0 and out_result equals dest_old.
- R12: Shifts (op 40 logical left, 41 logical right, 42 arithmetic right) shift opnd_a by the low log2(XLEN) bits of the second operand.
- R13: Any opcode not listed above gives out_wr_en=0 and out_trap=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 6 | Operation code |
| opnd_a | input | XLEN | First operand |
| opnd_b | input | XLEN | Second operand (register form) |
| use_lit | input | 1 | Select literal in place of opnd_b |
| lit | input | 8 | Literal, zero-extended |
| dest_old | input | XLEN | Current destination register value |
| out_valid | output | 1 | Result present |
| out_result | output | XLEN | Result word |
| out_wr_en | output | 1 | Destination write-enable |
| out_trap | output | 1 | Overflow trap request |

## Verification
The bench builds the unit with XLEN=16 and HALF=8, which keeps the longword half narrow enough that carries, sign boundaries and overflow edges of both widths fall inside a sixteen-value operand corner set. At that size every one of the 64 opcode codes is crossed with every pair from that set, and every literal value from 0 to 255 is swept through add, compare, shift and conditional move, which also covers all sixteen shift amounts.

// File: rtl/iou_pkg.sv
`timescale 1ns/1ps
package iou_pkg;

  localparam int OPW  = 6;
  localparam int LITW = 8;

  // op[5:3] selects the function group
  localparam logic [2:0] GRP_ARITH  = 3'd0;
  localparam logic [2:0] GRP_SCALED = 3'd1;
  localparam logic [2:0] GRP_CMP    = 3'd2;
  localparam logic [2:0] GRP_LOGIC  = 3'd3;
  localparam logic [2:0] GRP_CMOV   = 3'd4;
  localparam logic [2:0] GRP_SHIFT  = 3'd5;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shift_kind_t;

endpackage

// File: rtl/iou_addsub.sv
`timescale 1ns/1ps
module iou_addsub #(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            long_i,
  input  logic [1:0]      shamt_i,
  input  logic            chk_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o
);

  localparam int HMSB = HALF - 1;
  localparam int XMSB = XLEN - 1;

  logic [XLEN-1:0] b_scaled;
  logic [XLEN-1:0] b_term;
  logic [XLEN-1:0] raw;
  logic            ovf_quad;
  logic            ovf_long;

  // One adder serves both widths: the low HALF bits of the full sum are
  // the longword sum, because the carry-in enters at bit 0.
  always_comb begin
    b_scaled = b_i << shamt_i;
    b_term   = sub_i ? ~b_scaled : b_scaled;
    raw      = a_i + b_term + {{(XLEN-1){1'b0}}, sub_i};
    ovf_quad = (a_i[XMSB] == b_term[XMSB]) && (raw[XMSB] != a_i[XMSB]);
    ovf_long = (a_i[HMSB] == b_term[HMSB]) && (raw[HMSB] != a_i[HMSB]);
    sum_o    = long_i ? {{(XLEN-HALF){raw[HMSB]}}, raw[HMSB:0]} : raw;
    ovf_o    = chk_i & (long_i ? ovf_long : ovf_quad);
  end

endmodule

// File: rtl/iou_compare.sv
`timescale 1ns/1ps
module iou_compare #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      sel_i,
  output logic            cmp_o,
  output logic            take_o
);

  logic eq, slt, ult, a_neg, a_zero;

  always_comb begin
    eq     = (a_i == b_i);
    slt    = ($signed(a_i) < $signed(b_i));
    ult    = (a_i < b_i);
    a_neg  = a_i[XLEN-1];
    a_zero = (a_i == '0);

    unique case (sel_i)
      3'd0:    cmp_o = eq;
      3'd1:    cmp_o = slt;
      3'd2:    cmp_o = slt | eq;
      3'd3:    cmp_o = ult;
      3'd4:    cmp_o = ult | eq;
      default: cmp_o = 1'b0;
    endcase

    unique case (sel_i)
      3'd0:    take_o = a_zero;
      3'd1:    take_o = ~a_zero;
      3'd2:    take_o = a_neg;
      3'd3:    take_o = a_neg | a_zero;
      3'd4:    take_o = ~a_neg;
      3'd5:    take_o = ~a_neg & ~a_zero;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/iou_shift.sv
`timescale 1ns/1ps
module iou_shift
  import iou_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [SW-1:0]   amt_i,
  input  shift_kind_t     kind_i,
  output logic [XLEN-1:0] y_o
);

  logic            go_left;
  logic            fill;
  logic [XLEN-1:0] rev_in;
  logic [XLEN-1:0] rev_out;
  logic [XLEN-1:0] stage_in;
  logic [XLEN-1:0] stg [0:SW];

  assign go_left  = (kind_i == SH_LEFT);
  assign fill     = (kind_i == SH_ARITH) & a_i[XLEN-1];
  assign stage_in = go_left ? rev_in : a_i;
  assign stg[0]   = stage_in;

  // Left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev_in[i]  = a_i[XLEN-1-i];
    assign rev_out[i] = stg[SW][XLEN-1-i];
  end

  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stg[s+1] = amt_i[s]
                    ? {{(2**s){fill}}, stg[s][XLEN-1:(2**s)]}
                    : stg[s];
  end

  assign y_o = go_left ? rev_out : stg[SW];

endmodule

// File: rtl/iou_int_exec.sv
`timescale 1ns/1ps
module iou_int_exec
  import iou_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [5:0]        op,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic              use_lit,
  input  logic [7:0]        lit,
  input  logic [XLEN-1:0]   dest_old,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_result,
  output logic              out_wr_en,
  output logic              out_trap
);

  localparam int SW = $clog2(XLEN);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // ---------------- operand selection and decode ----------------
  logic [XLEN-1:0] b_eff;
  logic [2:0]      grp;
  logic [2:0]      sel;
  logic            as_sub, as_long, as_chk;
  logic [1:0]      as_shamt;
  logic [XLEN-1:0] as_sum;
  logic            as_ovf;
  logic            cmp_bit, cmov_take;
  logic [XLEN-1:0] sh_res;
  shift_kind_t     sh_kind;

  assign b_eff = use_lit ? {{(XLEN-LITW){1'b0}}, lit} : opnd_b;
  assign grp   = op[5:3];
  assign sel   = op[2:0];

  always_comb begin
    if (grp == GRP_SCALED) begin
      as_sub   = op[1];
      as_long  = op[2];
      as_chk   = 1'b0;
      as_shamt = op[0] ? 2'd3 : 2'd2;
    end else begin
      as_sub   = op[0];
      as_long  = op[1];
      as_chk   = op[2];
      as_shamt = 2'd0;
    end
    sh_kind = shift_kind_t'(op[1:0]);
  end

  iou_addsub #(.XLEN(XLEN), .HALF(HALF)) u_addsub (
    .a_i(opnd_a), .b_i(b_eff), .sub_i(as_sub), .long_i(as_long),
    .shamt_i(as_shamt), .chk_i(as_chk), .sum_o(as_sum), .ovf_o(as_ovf)
  );

  iou_compare #(.XLEN(XLEN)) u_cmp (
    .a_i(opnd_a), .b_i(b_eff), .sel_i(sel), .cmp_o(cmp_bit), .take_o(cmov_take)
  );

  iou_shift #(.XLEN(XLEN)) u_shift (
    .a_i(opnd_a), .amt_i(b_eff[SW-1:0]), .kind_i(sh_kind), .y_o(sh_res)
  );

  // ---------------- next-state ----------------
  logic [XLEN-1:0] res_n;
  logic            we_n;
  logic            trap_n;

  always_comb begin
    res_n  = '0;
    we_n   = 1'b0;
    trap_n = 1'b0;
    unique case (grp)
      GRP_ARITH: begin
        res_n  = as_sum;
        we_n   = 1'b1;
        trap_n = as_ovf;
      end
      GRP_SCALED: begin
        res_n = as_sum;
        we_n  = 1'b1;
      end
      GRP_CMP: begin
        res_n = {{(XLEN-1){1'b0}}, cmp_bit};
        we_n  = (sel <= 3'd4);
      end
      GRP_LOGIC: begin
        we_n = (sel <= 3'd5);
        unique case (sel)
          3'd0:    res_n = opnd_a & b_eff;
          3'd1:    res_n = opnd_a | b_eff;
          3'd2:    res_n = opnd_a ^ b_eff;
          3'd3:    res_n = ~(opnd_a & b_eff);
          3'd4:    res_n = ~(opnd_a | b_eff);
          3'd5:    res_n = ~(opnd_a ^ b_eff);
          default: res_n = '0;
        endcase
      end
      GRP_CMOV: begin
        we_n  = (sel <= 3'd5) & cmov_take;
        res_n = we_n ? b_eff : dest_old;
      end
      GRP_SHIFT: begin
        res_n = sh_res;
        we_n  = (sel <= 3'd2);
      end
      default: begin
        res_n  = '0;
        we_n   = 1'b0;
      end
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      out_wr_en <= 1'b0;
      out_trap  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr_en <= in_valid & we_n;
      out_trap  <= in_valid & trap_n;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_result <= res_n;
  end

  // ---------------- assertions ----------------
  logic long_op;
  assign long_op = ((grp == GRP_ARITH) & op[1]) | ((grp == GRP_SCALED) & op[2]);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> (!out_valid && !out_wr_en && !out_trap)); // R2

  AST_TRAP_CHECKED_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_trap |-> ($past(grp) == GRP_ARITH && $past(op[2]))); // R7

  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && $past(grp) == GRP_CMP) |-> (out_result[XLEN-1:1] == '0)); // R8

  AST_LONG_SEXT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && $past(long_op))
      |-> (out_result[XLEN-1:HALF] == {(XLEN-HALF){out_result[HALF-1]}})); // R5

  AST_CMOV_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_wr_en && $past(grp) == GRP_CMOV)
      |-> (out_result == $past(dest_old))); // R11

endmodule

// File: tb/sim_iou_int_exec.sv
`timescale 1ns/1ps
module sim_iou_int_exec;

  localparam int W  = 16;
  localparam int H  = 8;
  localparam int SW = $clog2(W);

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [5:0]    op;
  logic [W-1:0]  opnd_a, opnd_b, dest_old;
  logic          use_lit;
  logic [7:0]    lit;
  logic          out_valid, out_wr_en, out_trap;
  logic [W-1:0]  out_result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  iou_int_exec #(.XLEN(W), .HALF(H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .use_lit(use_lit), .lit(lit),
    .dest_old(dest_old), .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_trap(out_trap)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] corner(input int i);
    case (i)
      0:  return 16'h0000;  1:  return 16'h0001;
      2:  return 16'h0002;  3:  return 16'h007F;
      4:  return 16'h0080;  5:  return 16'h00FF;
      6:  return 16'h0100;  7:  return 16'h7FFF;
      8:  return 16'h8000;  9:  return 16'hFFFF;
      10: return 16'h1234;  11: return 16'hFEDC;
      12: return 16'h0F0F;  13: return 16'h8001;
      14: return 16'h7FFE;  default: return 16'h00C1;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] o, input logic take);
    case (o[5:3])
      3'd0: return o[2] ? "R7" : (o[1] ? "R5" : "R4");
      3'd1: return o[2] ? "R6/R5" : "R6";
      3'd2: return (o[2:0] <= 4) ? "R8" : "R13";
      3'd3: return (o[2:0] <= 5) ? "R9" : "R13";
      3'd4: return (o[2:0] <= 5) ? (take ? "R10" : "R11") : "R13";
      3'd5: return (o[2:0] <= 2) ? "R12" : "R13";
      default: return "R13";
    endcase
  endfunction

  // Reference model, written from the requirements
  task automatic model(input logic [5:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] dold, output logic [W-1:0] res,
                       output logic we, output logic trap, output logic take, output logic known);
    logic signed [W-1:0] sa, sb;
    logic signed [H-1:0] la, lb;
    logic [H-1:0]        lo;
    logic [W-1:0]        bs;
    longint              s;
    logic                sub, lng, chkd;
    res = '0; we = 0; trap = 0; take = 0; known = 0;
    sa = a;
    if (o[5:4] == 2'b00) begin
      known = 1;
      we    = 1;
      if (o[3]) begin
        sub = o[1]; lng = o[2]; chkd = 0;
        bs  = b * (o[0] ? 16'd8 : 16'd4);
      end else begin
        sub = o[0]; lng = o[1]; chkd = o[2];
        bs  = b;
      end
      if (lng) begin
        la = a[H-1:0]; lb = bs[H-1:0];
        s  = sub ? (longint'(la) - longint'(lb)) : (longint'(la) + longint'(lb));
        lo = s[H-1:0];
        res = {{(W-H){lo[H-1]}}, lo};
        trap = chkd && (s > longint'(2**(H-1) - 1) || s < -longint'(2**(H-1)));
      end else begin
        sb = bs;
        s  = sub ? (longint'(sa) - longint'(sb)) : (longint'(sa) + longint'(sb));
        res = s[W-1:0];
        trap = chkd && (s > longint'(2**(W-1) - 1) || s < -longint'(2**(W-1)));
      end
    end else begin
      sb = b;
      case (o)
        6'd16: begin known = 1; we = 1; res = {15'd0, a == b}; end
        6'd17: begin known = 1; we = 1; res = {15'd0, sa < sb}; end
        6'd18: begin known = 1; we = 1; res = {15'd0, sa <= sb}; end
        6'd19: begin known = 1; we = 1; res = {15'd0, a < b}; end
        6'd20: begin known = 1; we = 1; res = {15'd0, a <= b}; end
        6'd24: begin known = 1; we = 1; res = a & b; end
        6'd25: begin known = 1; we = 1; res = a | b; end
        6'd26: begin known = 1; we = 1; res = a ^ b; end
        6'd27: begin known = 1; we = 1; res = ~(a & b); end
        6'd28: begin known = 1; we = 1; res = ~(a | b); end
        6'd29: begin known = 1; we = 1; res = ~(a ^ b); end
        6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37: begin
          known = 1;
          case (o)
            6'd32: take = (sa == 0);
            6'd33: take = (sa != 0);
            6'd34: take = (sa < 0);
            6'd35: take = (sa <= 0);
            6'd36: take = (sa >= 0);
            default: take = (sa > 0);
          endcase
          we  = take;
          res = take ? b : dold;
        end
        6'd40: begin known = 1; we = 1; res = a << b[SW-1:0]; end
        6'd41: begin known = 1; we = 1; res = a >> b[SW-1:0]; end
        6'd42: begin known = 1; we = 1; res = sa >>> b[SW-1:0]; end
        default: begin known = 0; we = 0; end
      endcase
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic run(input logic [5:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic ul, input logic [7:0] l, input logic [W-1:0] dold,
                     input string extra);
    logic [W-1:0] r_e, b_e;
    logic we_e, tr_e, tk, kn;
    string t;
    op = o; opnd_a = a; opnd_b = b; use_lit = ul; lit = l; dest_old = dold;
    in_valid = 1'b1;
    b_e = ul ? {8'd0, l} : b;
    model(o, a, b_e, dold, r_e, we_e, tr_e, tk, kn);
    t = {tag_of(o, tk), extra};
    @(negedge clk);
    chk({t, " valid R2"}, {15'd0, out_valid}, 16'd1);
    chk({t, " wr_en"},    {15'd0, out_wr_en}, {15'd0, we_e});
    chk({t, " trap"},     {15'd0, out_trap},  {15'd0, tr_e});
    if (kn) chk({t, " result"}, out_result, r_e);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opnd_a = '0; opnd_b = '0;
    use_lit = 1'b0; lit = '0; dest_old = '0;
    @(negedge clk);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs stay quiet in reset even with in_valid high
    chk("R1 valid", {15'd0, out_valid}, 16'd0);
    chk("R1 wr_en", {15'd0, out_wr_en}, 16'd0);
    chk("R1 trap",  {15'd0, out_trap},  16'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    chk("R1 valid at release", {15'd0, out_valid}, 16'd0);
    repeat (3) @(negedge clk);
    chk("R1 valid after release", {15'd0, out_valid}, 16'd0);

    // Every opcode code crossed with every pair of corner operands
    for (int o = 0; o < 64; o++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          run(6'(o), corner(i), corner(j), 1'b0, 8'h00,
              corner(i) ^ 16'hA5C3 ^ 16'(j), "");
        end
      end
    end

    // R3: literal sweep; opnd_b carries junk that must not matter
    for (int l = 0; l < 256; l++) begin
      run(6'd0,  16'h1234, 16'hFFFF, 1'b1, 8'(l), 16'h0, " R3");
      run(6'd19, 16'h0040, 16'hFFFF, 1'b1, 8'(l), 16'h0, " R3");
      run(6'd40, 16'h8421, 16'hFFFF, 1'b1, 8'(l), 16'h0, " R3");
      run(6'd42, 16'h8421, 16'hFFFF, 1'b1, 8'(l), 16'h0, " R3");
      run(6'd36, 16'h0005, 16'hFFFF, 1'b1, 8'(l), 16'hBEEF, " R3");
    end

    // R2: an idle cycle produces no output
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 idle valid", {15'd0, out_valid}, 16'd0);
    chk("R2 idle wr_en", {15'd0, out_wr_en}, 16'd0);
    chk("R2 idle trap",  {15'd0, out_trap},  16'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule